// File: doc/BRIEF.md
# Serial Audio Transmitter with Bypass

This block turns stereo samples back into a serial audio stream. It runs on the incoming bit clock and word clock, and it uses the same format code as the matching receiver, so the output framing matches the input framing. For each half-frame it takes the sample for that channel, places its bits in the slots that the selected justification calls for, and sends them MSB first. All other slots carry zero.

A bypass control sends the raw serial input to the output through one register stage and skips the serializer. An open-drain select changes the output into a pull-low pair: the data pin is held at 0, and the enable is asserted only when a 0 bit has to be driven. A mute input forces the line low. Turning on open-drain and bypass together is an illegal setting. The block raises a flag for it and releases the line.

Top module: `audio_ser_tx`

## Requirements
- R1: `fmt_i[2]`=1 selects 24-bit samples in 32-slot half-frames. `fmt_i[1:0]` sets the first data slot: 00 right-justified (slot 8), 01 left-justified (slot 0), 10 I2S (slot 1). Bits go out MSB first.
- R2: In I2S a low word clock carries the left sample (`left_i`). In the two justified modes a high word clock carries the left sample.
- R3: `fmt_i[2]`=0 selects 16-slot half-frames that send the upper 16 bits of each sample. In I2S the LSB of a half-frame goes out in slot 0 of the next half-frame.
- R4: Slots that hold no data bit are sent as 0. This includes slots after the counter saturates when the word clock stops toggling.
- R5: A half-frame begins at the rising bit-clock edge that first samples a changed word clock, which is slot 0. The bit of slot k is registered at the rising edge of slot k and appears on `sdo_o` at the falling edge that follows. The sample is latched at slot 0.
- R6: With `bypass_i`=1 and `od_sel_i`=0, `sdo_o` shows the `sdi_i` value sampled at the previous rising edge, with `sdo_oe_o`=1.
- R7: With `od_sel_i`=1 and `bypass_i`=0, `sdo_o` stays 0 and `sdo_oe_o` is the inverse of the bit. In push-pull mode `sdo_oe_o`=1.
- R8: `od_sel_i`=1 together with `bypass_i`=1 sets `cfg_err_o` after the next rising edge. The line is then released (`sdo_o`=0, `sdo_oe_o`=0). Any other setting clears the flag.
- R9: While `mute_i`=1 the bit is 0. The line is actively driven low in both push-pull and open-drain modes.
- R10: `fmt_i[1:0]`=11 is a reserved format. The serializer then sends only zeros.
- R11: A synchronous low `rst_n` clears `cfg_err_o` and releases the line (`sdo_o`=0, `sdo_oe_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck_i | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lrclk_i | input | 1 | Word clock (channel select) |
| fmt_i | input | 3 | Format code: [2] width/rate, [1:0] justification |
| left_i | input | SAMPLE_W | Left sample, latched at slot 0 |
| right_i | input | SAMPLE_W | Right sample, latched at slot 0 |
| mute_i | input | 1 | Force the output low |
| sdi_i | input | 1 | Raw serial input used for bypass |
| od_sel_i | input | 1 | Open-drain select |
| bypass_i | input | 1 | Bypass select |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable |
| cfg_err_o | output | 1 | Illegal open-drain plus bypass setting |

## Verification
The bench builds the block with its default parameters: 24-bit and 16-bit samples in 32-slot and 16-slot half-frames. With these values all six formats can be reached. They also cover the eight-slot pad of right-justified 24-bit mode and the case where the 16-bit I2S LSB spills into the next half-frame. With the counter at six bits, a stopped word clock saturates the counter within the run. Every vector runs one warm-up frame and one checked frame, so the word latched from the other channel is always defined.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;

    typedef enum logic [1:0] {
        JUST_RIGHT = 2'b00,
        JUST_LEFT  = 2'b01,
        JUST_I2S   = 2'b10,
        JUST_RSVD  = 2'b11
    } just_e;

endpackage

// File: rtl/audio_tx_slot_ctr.sv
module audio_tx_slot_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             bck_i,
    input  logic             rst_n,
    input  logic             lr_i,
    output logic [CNT_W-1:0] slot_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             lr;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic turn;

    always_comb begin
        turn      = (lr_i != ctr_q.lr);
        slot_o    = turn ? '0 : ctr_q.cnt;
        ctr_d.lr  = lr_i;
        if (turn)
            ctr_d.cnt = CNT_W'(1);
        else if (ctr_q.cnt == CNT_MAX)
            ctr_d.cnt = CNT_MAX;
        else
            ctr_d.cnt = ctr_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge bck_i) begin
        if (!rst_n) begin
            ctr_q.lr  <= 1'b0;
            ctr_q.cnt <= CNT_MAX;
        end else begin
            ctr_q <= ctr_d;
        end
    end
endmodule

// File: rtl/audio_tx_bit_pick.sv
module audio_tx_bit_pick
    import audio_ser_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int NARROW_W    = 16,
    parameter int WIDE_HALF   = 32,
    parameter int NARROW_HALF = 16,
    parameter int CNT_W       = 6
) (
    input  logic [2:0]          fmt_i,
    input  logic [CNT_W-1:0]    slot_i,
    input  logic                lr_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic [SAMPLE_W-1:0] held_i,
    output logic [SAMPLE_W-1:0] word_o,
    output logic                bit_o,
    output logic                fmt_ok_o
);
    localparam int IW = $clog2(SAMPLE_W);

    just_e just;
    logic  chan_left;
    int    dlen, half, off, pos;

    always_comb begin
        just      = just_e'(fmt_i[1:0]);
        dlen      = fmt_i[2] ? SAMPLE_W : NARROW_W;
        half      = fmt_i[2] ? WIDE_HALF : NARROW_HALF;
        case (just)
            JUST_LEFT: off = 0;
            JUST_I2S:  off = 1;
            default:   off = half - dlen;
        endcase
        fmt_ok_o  = (just != JUST_RSVD);
        chan_left = (just == JUST_I2S) ? !lr_i : lr_i;
        word_o    = (slot_i == '0) ? (chan_left ? left_i : right_i) : held_i;
        pos       = int'(slot_i) - off;
        bit_o     = 1'b0;
        if (just == JUST_I2S && slot_i == '0 && dlen == half)
            bit_o = held_i[IW'(SAMPLE_W - dlen)];
        else if (pos >= 0 && pos < dlen)
            bit_o = word_o[IW'(SAMPLE_W - 1 - pos)];
        if (!fmt_ok_o)
            bit_o = 1'b0;
    end
endmodule

// File: rtl/audio_tx_pin.sv
module audio_tx_pin (
    input  logic bck_i,
    input  logic rst_n,
    input  logic txd_i,
    input  logic od_i,
    input  logic err_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    typedef struct packed {
        logic sdo;
        logic oe;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        if (err_i)
            pin_d = '{sdo: 1'b0, oe: 1'b0};
        else if (od_i)
            pin_d = '{sdo: 1'b0, oe: !txd_i};
        else
            pin_d = '{sdo: txd_i, oe: 1'b1};
    end

    always_ff @(negedge bck_i) begin
        if (!rst_n)
            pin_q <= '0;
        else
            pin_q <= pin_d;
    end

    assign sdo_o    = pin_q.sdo;
    assign sdo_oe_o = pin_q.oe;
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
    parameter int SAMPLE_W    = 24,
    parameter int NARROW_W    = 16,
    parameter int WIDE_HALF   = 32,
    parameter int NARROW_HALF = 16
) (
    input  logic                bck_i,
    input  logic                rst_n,
    input  logic                lrclk_i,
    input  logic [2:0]          fmt_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic                mute_i,
    input  logic                sdi_i,
    input  logic                od_sel_i,
    input  logic                bypass_i,
    output logic                sdo_o,
    output logic                sdo_oe_o,
    output logic                cfg_err_o
);
    localparam int CNT_W = $clog2(WIDE_HALF) + 1;

    typedef struct packed {
        logic                txd;
        logic                od;
        logic                err;
        logic [SAMPLE_W-1:0] word;
    } tx_t;

    tx_t                 st_d, st_q;
    logic [CNT_W-1:0]    slot;
    logic [SAMPLE_W-1:0] word_now;
    logic                pick_bit, fmt_ok;

    audio_tx_slot_ctr #(.CNT_W(CNT_W)) u_ctr (
        .bck_i  (bck_i),
        .rst_n  (rst_n),
        .lr_i   (lrclk_i),
        .slot_o (slot)
    );

    audio_tx_bit_pick #(
        .SAMPLE_W    (SAMPLE_W),
        .NARROW_W    (NARROW_W),
        .WIDE_HALF   (WIDE_HALF),
        .NARROW_HALF (NARROW_HALF),
        .CNT_W       (CNT_W)
    ) u_pick (
        .fmt_i    (fmt_i),
        .slot_i   (slot),
        .lr_i     (lrclk_i),
        .left_i   (left_i),
        .right_i  (right_i),
        .held_i   (st_q.word),
        .word_o   (word_now),
        .bit_o    (pick_bit),
        .fmt_ok_o (fmt_ok)
    );

    always_comb begin
        st_d.word = word_now;
        st_d.od   = od_sel_i;
        st_d.err  = od_sel_i && bypass_i;
        if (mute_i)
            st_d.txd = 1'b0;
        else if (bypass_i)
            st_d.txd = sdi_i;
        else if (!fmt_ok)
            st_d.txd = 1'b0;
        else
            st_d.txd = pick_bit;
    end

    always_ff @(posedge bck_i) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    audio_tx_pin u_pin (
        .bck_i    (bck_i),
        .rst_n    (rst_n),
        .txd_i    (st_q.txd),
        .od_i     (st_q.od),
        .err_i    (st_q.err),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o)
    );

    assign cfg_err_o = st_q.err;
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
    input logic bck_i,
    input logic rst_n,
    input logic od_sel_i,
    input logic bypass_i,
    input logic mute_i,
    input logic sdi_i,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic cfg_err_o
);
    AST_RSV_SET: assert property (@(posedge bck_i) disable iff (!rst_n)
        (od_sel_i && bypass_i) |=> cfg_err_o);                           // R8
    AST_RSV_CLR: assert property (@(posedge bck_i) disable iff (!rst_n)
        !(od_sel_i && bypass_i) |=> !cfg_err_o);                         // R8
    AST_OD_NO_HIGH: assert property (@(posedge bck_i) disable iff (!rst_n)
        od_sel_i |=> !sdo_o);                                            // R7
    AST_PP_DRIVE: assert property (@(posedge bck_i) disable iff (!rst_n)
        !od_sel_i |=> sdo_oe_o);                                         // R7
    AST_BYP_FOLLOW: assert property (@(posedge bck_i) disable iff (!rst_n)
        (bypass_i && !od_sel_i && !mute_i) |=> (sdo_o == $past(sdi_i))); // R6
    AST_MUTE_PP: assert property (@(posedge bck_i) disable iff (!rst_n)
        (mute_i && !od_sel_i) |=> (!sdo_o && sdo_oe_o));                 // R9
    AST_MUTE_OD: assert property (@(posedge bck_i) disable iff (!rst_n)
        (mute_i && od_sel_i && !bypass_i) |=> sdo_oe_o);                 // R9
    AST_RST_FLAG: assert property (@(posedge bck_i)
        !rst_n |=> !cfg_err_o);                                          // R11
    AST_RST_LINE: assert property (@(negedge bck_i)
        !rst_n |=> (!sdo_o && !sdo_oe_o));                               // R11
endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (
    .bck_i     (bck_i),
    .rst_n     (rst_n),
    .od_sel_i  (od_sel_i),
    .bypass_i  (bypass_i),
    .mute_i    (mute_i),
    .sdi_i     (sdi_i),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/sim_audio_ser_tx.sv
`timescale 1ns/1ps
module sim_audio_ser_tx;
    logic        clk_bit = 1'b0;
    logic        rst_n;
    logic        lrclk;
    logic [2:0]  fmt;
    logic [23:0] left, right;
    logic        mute, sdi, od_sel, bypass;
    logic        sdo, sdo_oe, cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk_bit = ~clk_bit;

    audio_ser_tx u0 (
        .bck_i (clk_bit), .rst_n (rst_n), .lrclk_i (lrclk), .fmt_i (fmt),
        .left_i (left), .right_i (right), .mute_i (mute), .sdi_i (sdi),
        .od_sel_i (od_sel), .bypass_i (bypass),
        .sdo_o (sdo), .sdo_oe_o (sdo_oe), .cfg_err_o (cfg_err)
    );

    typedef struct packed {
        logic [2:0]  f;
        logic        od;
        logic        byp;
        logic        mu;
        logic [23:0] l;
        logic [23:0] r;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{3'b110, 1'b0, 1'b0, 1'b0, 24'hC3A518, 24'h5A6E81},
        '{3'b101, 1'b0, 1'b0, 1'b0, 24'h9D0F37, 24'h62B4C9},
        '{3'b100, 1'b0, 1'b0, 1'b0, 24'hE1784B, 24'h1E87B4},
        '{3'b010, 1'b0, 1'b0, 1'b0, 24'hB3C1FF, 24'h4C3E01},
        '{3'b001, 1'b0, 1'b0, 1'b0, 24'h8F21AA, 24'h70DE55},
        '{3'b000, 1'b0, 1'b0, 1'b0, 24'hA6593C, 24'h59A6C3},
        '{3'b110, 1'b1, 1'b0, 1'b0, 24'hF0C387, 24'h0F3C78},
        '{3'b000, 1'b1, 1'b0, 1'b0, 24'hD2B400, 24'h2D4BFF},
        '{3'b101, 1'b0, 1'b0, 1'b1, 24'hFFFFFF, 24'hFFFFFF},
        '{3'b111, 1'b0, 1'b0, 1'b0, 24'hFFFFFF, 24'hAAAAAA},
        '{3'b101, 1'b0, 1'b1, 1'b0, 24'h000000, 24'h000000},
        '{3'b110, 1'b1, 1'b1, 1'b0, 24'hFFFFFF, 24'hFFFFFF}
    };

    logic [1:0] e_sdo, e_oe;
    logic [1:0] e_ok;
    string      e_req [2];
    logic [15:0] lfsr = 16'hACE1;

    function automatic string req_of(vec_t v);
        if (v.od && v.byp) return "R8";
        if (v.mu)          return "R9";
        if (v.byp)         return "R6";
        if (v.f[1:0] == 2'b11) return "R10";
        if (v.od)          return "R7 R1";
        if (v.f[2])        return "R1 R2 R4 R5";
        return "R3 R2 R4 R5";
    endfunction

    function automatic void model(input vec_t v, input logic lr, input int s,
                                  input logic din, output logic es, output logic eo);
        int d, h, off, j;
        logic chl, b;
        logic [23:0] w, wo;
        d   = v.f[2] ? 24 : 16;
        h   = v.f[2] ? 32 : 16;
        j   = int'(v.f[1:0]);
        off = (j == 1) ? 0 : (j == 2) ? 1 : h - d;
        chl = (j == 2) ? !lr : lr;
        w   = chl ? v.l : v.r;
        wo  = chl ? v.r : v.l;
        b   = 1'b0;
        if (j == 3)
            b = 1'b0;
        else if (j == 2 && s == 0 && d == h)
            b = wo[24 - d];
        else if (s >= off && s - off < d)
            b = w[23 - (s - off)];
        if (v.byp) b = din;
        if (v.mu)  b = 1'b0;
        if (v.od && v.byp) begin es = 1'b0; eo = 1'b0; end
        else if (v.od)     begin es = 1'b0; eo = !b;   end
        else               begin es = b;    eo = 1'b1; end
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {sdo,oe} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_err(input string req, input logic exp);
        n_chk++;
        if (cfg_err !== exp) begin
            n_fail++;
            $display("FAIL %s: cfg_err actual %b expected %b at %0t", req, cfg_err, exp, $time);
        end
    endtask

    // inputs already driven; push expectation, advance one bit period, compare the one before
    task automatic step(input logic chk, input logic es, input logic eo, input string req);
        e_ok[1] = e_ok[0]; e_sdo[1] = e_sdo[0]; e_oe[1] = e_oe[0]; e_req[1] = e_req[0];
        e_ok[0] = chk;     e_sdo[0] = es;       e_oe[0] = eo;     e_req[0] = req;
        @(posedge clk_bit); #1;
        if (e_ok[1]) check(e_req[1], {sdo, sdo_oe}, {e_sdo[1], e_oe[1]});
    endtask

    task automatic drive(input vec_t v, input logic lr, input int s, input logic chk);
        logic es, eo;
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdi   = lfsr[0];
        lrclk = lr;
        fmt = v.f; od_sel = v.od; bypass = v.byp; mute = v.mu; left = v.l; right = v.r;
        model(v, lr, s, sdi, es, eo);
        step(chk, es, eo, req_of(v));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        e_ok = '0;
        rst_n = 1'b0; lrclk = 1'b0; fmt = 3'b110; left = '0; right = '0;
        mute = 1'b0; sdi = 1'b0; od_sel = 1'b1; bypass = 1'b1;
        repeat (3) @(posedge clk_bit);
        #1;
        // R11: reset state even with the illegal setting applied
        check("R11", {sdo, sdo_oe}, 2'b00);
        check_err("R11", 1'b0);
        od_sel = 1'b0; bypass = 1'b0;
        @(posedge clk_bit); #1;
        rst_n = 1'b1;

        for (int vi = 0; vi < NV; vi++) begin
            vec_t v;
            int   h;
            v = VEC[vi];
            h = v.f[2] ? 32 : 16;
            for (int fr = 0; fr < 2; fr++)
                for (int hf = 0; hf < 2; hf++)
                    for (int s = 0; s < h; s++)
                        drive(v, (v.f[1:0] == 2'b10) ? hf[0] : !hf[0], s, fr == 1);
            check_err("R8", v.od && v.byp);
        end

        // R4: word clock stops toggling, counter saturates, all later slots zero
        begin
            vec_t v;
            logic lr0;
            v   = VEC[1];
            lr0 = !lrclk;
            for (int s = 0; s < 90; s++) drive(v, lr0, s, 1'b1);
            for (int s = 0; s < 32; s++) drive(v, !lr0, s, 1'b1);
        end

        // R8: leaving the illegal setting clears the flag
        drive(VEC[11], 1'b0, 0, 1'b0);
        drive(VEC[11], 1'b1, 0, 1'b0);
        check_err("R8", 1'b1);
        drive(VEC[0], 1'b0, 0, 1'b0);
        check_err("R8", 1'b0);

        // R11: reset in mid-stream releases the line
        od_sel = 1'b0; bypass = 1'b0; fmt = 3'b101; left = '1; lrclk = !lrclk;
        rst_n = 1'b0;
        @(posedge clk_bit); @(negedge clk_bit); #1;
        check("R11", {sdo, sdo_oe}, 2'b00);
        check_err("R11", 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule